// File: doc/BRIEF.md
# Prioritised Level-Interrupt Router

This block gathers level-sensitive interrupt requests from a parameterised set of global sources and routes them to several target contexts. Each context could be one privilege level of one processor thread. Every source has a programmable priority. Every context has its own enable bitmap, a priority floor (threshold) and a claim/complete register. A gateway in each source turns a held level into a single pending request. For each context, an arbiter picks the best enabled pending source. The context's interrupt line is high while that pick is nonzero.

Software services an interrupt with a read and a write. Reading a context's claim register returns the winning source ID and clears its pending bit, so no other context can take the same request. Writing that ID back to the claim register re-opens the source's gateway. Between the claim and the completion the source is blocked, even if its level stays high, so no separate mask register exists. Registers sit on a single-cycle 32-bit bus with byte addresses and a registered read path.

Top module: `prio_irq_hub`

## Requirements
- R1: After reset, every priority, enable and threshold register reads 0, every interrupt output is low, and a claim read returns 0.
- R2: The priority of source n sits at byte address 4*n. Only the low PRIO_W bits are stored, and the upper bits read as 0. The word for ID 0 always reads 0 and ignores writes.
- R3: The enable bitmap of context c starts at 0x2000 + 0x80*c. Source n is enabled by bit n%32 of word n/32. Bit 0 and bits above N_SRC read 0 and cannot be set.
- R4: The threshold of context c is at 0x200000 + 0x1000*c, and its claim/complete register is at that address plus 4.
- R5: A source is eligible for a context only when it is pending, enabled for that context, and its priority is strictly greater than the context's threshold. A priority of 0 is never eligible.
- R6: Among eligible sources the highest priority wins. When priorities are equal, the lower ID wins.
- R7: Interrupt output c is high exactly when context c has an eligible source. It follows the stored state in the same cycle, with no register in between.
- R8: A claim read returns the ID of the current winner for that context and clears that source's pending bit. When nothing is eligible the read returns 0 and changes nothing.
- R9: A gateway latches a pending request from a high level only when the source is not already in flight. A level held high after a claim does not re-pend the source.
- R10: A completion write carrying the ID of a claimed source frees its gateway at that clock edge. A level that is still high becomes pending at the following edge.
- R11: A completion write carrying 0, an ID above N_SRC, or the ID of a source that is not claimed is ignored.
- R12: Reads of unmapped or misaligned addresses (low two bits nonzero) return 0, and writes to them are dropped.
- R13: Read data appears on bus_rdata in the cycle after the read access, and is 0 after any cycle that was not a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | N_SRC | Level request inputs; bit i-1 is source ID i |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 22 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | N_CTX | Interrupt line per context |

## Verification
The checker watches several properties on every cycle:
- a pending bit never exists without its source being in flight;
- a pending bit only rises out of the idle gateway state;
- an interrupt line never rises without some pending source;
- a claim read taken while the line is low returns 0;
- reset silences the outputs.

Other behaviour depends on register contents and only the bench's scenarios can show it: the strict threshold compare, tie-breaking toward the lower ID, the one-cycle gap before a completed source re-pends, the masking of priority and enable fields, and the rejection of bogus completions. A bench model of the register map and gateways tracks these through directed cases and random traffic.

// File: rtl/irqh_pkg.sv
package irqh_pkg;

  localparam int ADDR_W = 22;

  // Region bases; decode of the bus depends on these exact offsets.
  localparam logic [ADDR_W-1:0] EN_BASE  = 22'h002000;
  localparam logic [ADDR_W-1:0] CTX_BASE = 22'h200000;
  localparam int EN_STRIDE_LG  = 7;   // 0x80 per context
  localparam int CTX_STRIDE_LG = 12;  // 0x1000 per context

  typedef enum logic [2:0] {
    RK_NONE,
    RK_PRIO,
    RK_EN,
    RK_THR,
    RK_CLAIM
  } reg_kind_e;

endpackage

// File: rtl/irqh_gateway.sv
module irqh_gateway (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic take,
  input  logic done,
  output logic pend,
  output logic busy
);

  // busy covers pending plus claimed; a new request is only taken when idle.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      busy <= 1'b0;
    end else if (!busy && lvl) begin
      pend <= 1'b1;
      busy <= 1'b1;
    end else begin
      if (take) pend <= 1'b0;
      if (done) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/irqh_arbiter.sv
module irqh_arbiter #(
  parameter int N_SRC  = 40,
  parameter int PRIO_W = 3,
  parameter int IDW    = 6
) (
  input  logic [N_SRC:1]             req,
  input  logic [N_SRC:1][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]          thr,
  output logic [IDW-1:0]             win_id
);

  logic [PRIO_W-1:0] best_p;

  // Seeding with the threshold enforces the strict compare; scanning upward
  // with '>' keeps the lower ID on equal priority.
  always_comb begin
    best_p = thr;
    win_id = '0;
    for (int i = 1; i <= N_SRC; i++) begin
      if (req[i] && (prio[i] > best_p)) begin
        best_p = prio[i];
        win_id = IDW'(i);
      end
    end
  end

endmodule

// File: rtl/prio_irq_hub.sv
module prio_irq_hub
  import irqh_pkg::*;
#(
  parameter int N_SRC  = 40,
  parameter int N_CTX  = 2,
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_lvl,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [21:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N_CTX-1:0]  irq_out
);

  localparam int IDW      = $clog2(N_SRC + 1);
  localparam int EN_WORDS = (N_SRC + 32) / 32;
  localparam int EN_BITS  = EN_WORDS * 32;
  localparam int CTX_W    = (N_CTX > 1) ? $clog2(N_CTX) : 1;
  localparam int WORD_W   = (EN_WORDS > 1) ? $clog2(EN_WORDS) : 1;
  localparam logic [ADDR_W-1:0] PRIO_END = ADDR_W'((N_SRC + 1) * 4);
  localparam logic [ADDR_W-1:0] EN_SPAN  = ADDR_W'(N_CTX << EN_STRIDE_LG);
  localparam logic [ADDR_W-1:0] CTX_SPAN = ADDR_W'(N_CTX << CTX_STRIDE_LG);

  function automatic logic [EN_BITS-1:0] en_mask_f();
    logic [EN_BITS-1:0] m;
    m = '0;
    for (int i = 1; i <= N_SRC; i++) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [EN_BITS-1:0] EN_MASK = en_mask_f();

  // Register state
  logic [N_SRC:1][PRIO_W-1:0]    prio_q;
  logic [N_CTX-1:0][EN_BITS-1:0] en_q;
  logic [N_CTX-1:0][PRIO_W-1:0]  thr_q;

  // Gateway and arbitration state
  logic [N_SRC:1]              pend_vec, busy_vec, take_vec, done_vec;
  logic [N_CTX-1:0][IDW-1:0]   arb_id;

  // Address decode
  reg_kind_e             dec_kind;
  logic [CTX_W-1:0]      dec_ctx;
  logic [IDW-1:0]        dec_idx;
  logic [WORD_W-1:0]     dec_word;
  logic [ADDR_W-1:0]     a_rel;

  always_comb begin
    dec_kind = RK_NONE;
    dec_ctx  = '0;
    dec_idx  = '0;
    dec_word = '0;
    a_rel    = '0;
    if (bus_addr[1:0] != 2'b00) begin
      dec_kind = RK_NONE;
    end else if (bus_addr >= CTX_BASE) begin
      a_rel = bus_addr - CTX_BASE;
      if (a_rel < CTX_SPAN) begin
        dec_ctx = CTX_W'(a_rel >> CTX_STRIDE_LG);
        if (a_rel[11:2] == 10'd0)      dec_kind = RK_THR;
        else if (a_rel[11:2] == 10'd1) dec_kind = RK_CLAIM;
      end
    end else if (bus_addr >= EN_BASE) begin
      a_rel = bus_addr - EN_BASE;
      if (a_rel < EN_SPAN) begin
        dec_ctx = CTX_W'(a_rel >> EN_STRIDE_LG);
        if ({1'b0, a_rel[6:2]} < 6'(EN_WORDS)) begin
          dec_word = WORD_W'(a_rel[6:2]);
          dec_kind = RK_EN;
        end
      end
    end else if (bus_addr < PRIO_END) begin
      dec_idx  = IDW'(bus_addr >> 2);
      dec_kind = RK_PRIO;
    end
  end

  // Claim and completion strobes
  logic           claim_rd, cmp_wr;
  logic [IDW-1:0] claim_id;

  assign claim_rd = bus_sel && !bus_we && (dec_kind == RK_CLAIM);
  assign cmp_wr   = bus_sel &&  bus_we && (dec_kind == RK_CLAIM);
  assign claim_id = arb_id[dec_ctx];

  // One gateway per source
  for (genvar i = 1; i <= N_SRC; i++) begin : g_src
    assign take_vec[i] = claim_rd && (claim_id == IDW'(i));
    assign done_vec[i] = cmp_wr && (bus_wdata == 32'(i)) &&
                         busy_vec[i] && !pend_vec[i];
    irqh_gateway gw_i (
      .clk  (clk),
      .rst  (rst),
      .lvl  (src_lvl[i-1]),
      .take (take_vec[i]),
      .done (done_vec[i]),
      .pend (pend_vec[i]),
      .busy (busy_vec[i])
    );
  end

  // One arbiter per context
  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    logic [N_SRC:1] req_c;
    assign req_c = pend_vec & en_q[c][N_SRC:1];
    irqh_arbiter #(
      .N_SRC  (N_SRC),
      .PRIO_W (PRIO_W),
      .IDW    (IDW)
    ) arb_i (
      .req    (req_c),
      .prio   (prio_q),
      .thr    (thr_q[c]),
      .win_id (arb_id[c])
    );
    assign irq_out[c] = (arb_id[c] != '0);
  end

  // Read mux
  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (dec_kind)
      RK_PRIO:  if (dec_idx != '0) rd_next = 32'(prio_q[dec_idx]);
      RK_EN:    rd_next = en_q[dec_ctx][32*dec_word +: 32];
      RK_THR:   rd_next = 32'(thr_q[dec_ctx]);
      RK_CLAIM: rd_next = 32'(claim_id);
      default:  rd_next = '0;
    endcase
  end

  // Register writes and registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q    <= '0;
      en_q      <= '0;
      thr_q     <= '0;
      bus_rdata <= '0;
    end else begin
      bus_rdata <= (bus_sel && !bus_we) ? rd_next : 32'd0;
      if (bus_sel && bus_we) begin
        case (dec_kind)
          RK_PRIO: if (dec_idx != '0) prio_q[dec_idx] <= bus_wdata[PRIO_W-1:0];
          RK_EN:   en_q[dec_ctx][32*dec_word +: 32] <=
                     bus_wdata & EN_MASK[32*dec_word +: 32];
          RK_THR:  thr_q[dec_ctx] <= bus_wdata[PRIO_W-1:0];
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/irqh_checker.sv
module irqh_checker
  import irqh_pkg::*;
#(
  parameter int N_SRC = 40,
  parameter int N_CTX = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [21:0]      bus_addr,
  input logic [31:0]      bus_rdata,
  input logic [N_CTX-1:0] irq_out,
  input logic [N_SRC:1]   pend_vec,
  input logic [N_SRC:1]   busy_vec
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (irq_out == '0) && (bus_rdata == 32'd0));

  // R9
  pend_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_vec & ~busy_vec) == '0);

  // R7
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_out != '0) |-> (pend_vec != '0));

  for (genvar i = 1; i <= N_SRC; i++) begin : g_s
    // R9
    latch_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_vec[i]) |-> $past(!busy_vec[i]));
  end

  for (genvar c = 0; c < N_CTX; c++) begin : g_c
    localparam logic [21:0] CLM_A = CTX_BASE + 22'((c << CTX_STRIDE_LG) + 4);
    // R8
    idle_claim_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && !bus_we && (bus_addr == CLM_A) && !irq_out[c])
        |=> (bus_rdata == 32'd0));
  end

endmodule

bind prio_irq_hub irqh_checker #(.N_SRC(N_SRC), .N_CTX(N_CTX)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .pend_vec  (pend_vec),
  .busy_vec  (busy_vec)
);

// File: tb/prio_irq_hub_tb_top.sv
`timescale 1ns/1ps
module prio_irq_hub_tb_top;

  localparam int N_SRC = 40;
  localparam int N_CTX = 2;
  localparam int PRIO_W = 3;
  localparam int PMAX = (1 << PRIO_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N_SRC-1:0] lvl = '0;
  logic             bus_sel = 1'b0, bus_we = 1'b0;
  logic [21:0]      bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic [N_CTX-1:0] irq_out;

  int n_chk = 0, n_err = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  prio_irq_hub #(.N_SRC(N_SRC), .N_CTX(N_CTX), .PRIO_W(PRIO_W)) dut_i (
    .clk(clk), .rst(rst), .src_lvl(lvl), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out));

  // Model of the requirements
  int unsigned m_prio [0:N_SRC];
  logic [63:0] m_en   [N_CTX];
  int unsigned m_thr  [N_CTX];
  bit          m_pend [0:N_SRC];
  bit          m_busy [0:N_SRC];

  function automatic logic [21:0] a_prio(int n); return 22'(n * 4); endfunction
  function automatic logic [21:0] a_en(int c, int w); return 22'(32'h2000 + c*128 + w*4); endfunction
  function automatic logic [21:0] a_thr(int c); return 22'(32'h200000 + c*4096); endfunction
  function automatic logic [21:0] a_clm(int c); return 22'(32'h200004 + c*4096); endfunction

  function automatic int best(int c);
    int unsigned bp = m_thr[c];
    int id = 0;
    for (int i = 1; i <= N_SRC; i++)
      if (m_pend[i] && m_en[c][i] && m_prio[i] > bp) begin bp = m_prio[i]; id = i; end
    return id;
  endfunction

  // kind: 0 none, 1 prio, 2 enable, 3 threshold, 4 claim
  task automatic m_decode(input logic [21:0] a, output int kind, output int ctx, output int idx);
    int unsigned u = a;
    kind = 0; ctx = 0; idx = 0;
    if (u[1:0] != 0) return;
    if (u >= 32'h200000) begin
      u -= 32'h200000; ctx = int'(u >> 12);
      if (ctx < N_CTX) begin
        if ((u & 32'hFFF) == 0) kind = 3;
        else if ((u & 32'hFFF) == 4) kind = 4;
      end
    end else if (u >= 32'h2000) begin
      u -= 32'h2000; ctx = int'(u >> 7); idx = int'((u >> 2) & 31);
      if (ctx < N_CTX && idx < 2) kind = 2;
    end else if (u <= N_SRC * 4) begin
      kind = 1; idx = int'(u >> 2);
    end
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One bus cycle; called at a negedge, returns at the next negedge.
  task automatic cyc(input bit sel, input bit we, input logic [21:0] a,
                     input logic [31:0] wd, output logic [31:0] rd);
    int kind, ctx, idx, cl_id;
    logic [31:0] exp;
    logic [63:0] msk;
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd;
    m_decode(a, kind, ctx, idx);
    exp = 0; cl_id = 0;
    if (sel && !we) begin
      case (kind)
        1: exp = (idx == 0) ? 0 : m_prio[idx];
        2: exp = m_en[ctx][idx*32 +: 32];
        3: exp = m_thr[ctx];
        4: begin cl_id = best(ctx); exp = cl_id; end
        default: exp = 0;
      endcase
    end
    for (int i = 1; i <= N_SRC; i++) begin
      if (!m_busy[i] && lvl[i-1]) begin m_pend[i] = 1; m_busy[i] = 1; end
      else begin
        if (i == cl_id) m_pend[i] = 0;
        if (sel && we && kind == 4 && wd == i && m_busy[i] && !m_pend[i]) m_busy[i] = 0;
      end
    end
    if (sel && we) begin
      case (kind)
        1: if (idx != 0) m_prio[idx] = wd & PMAX;
        2: begin
             msk = '0;
             for (int i = 1; i <= N_SRC; i++) msk[i] = 1'b1;
             m_en[ctx][idx*32 +: 32] = wd & msk[idx*32 +: 32];
           end
        3: m_thr[ctx] = wd & PMAX;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    rd = bus_rdata;
    if (sel && !we) chk(rd == exp, "R8/R13 read data", rd, exp);
    else chk(rd == 0, "R13 idle read data", rd, 0);
    for (int c = 0; c < N_CTX; c++)
      chk(irq_out[c] == (best(c) != 0), "R7 irq line", 32'(irq_out[c]), 32'(best(c) != 0));
  endtask

  task automatic wr(input logic [21:0] a, input logic [31:0] d);
    logic [31:0] r; cyc(1, 1, a, d, r);
  endtask
  task automatic rd(input logic [21:0] a, output logic [31:0] r);
    cyc(1, 0, a, 0, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_err++;
      $display("FAIL watchdog expired");
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    for (int i = 0; i <= N_SRC; i++) begin m_prio[i] = 0; m_pend[i] = 0; m_busy[i] = 0; end
    for (int c = 0; c < N_CTX; c++) begin m_en[c] = '0; m_thr[c] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk(irq_out == 0, "R1 irq after reset", 32'(irq_out), 0);
    rd(a_clm(0), r);  chk(r == 0, "R1 claim after reset", r, 0);
    rd(a_prio(5), r); chk(r == 0, "R1 prio after reset", r, 0);
    rd(a_thr(1), r);  chk(r == 0, "R1 thr after reset", r, 0);

    // R2 field masking, ID 0 word
    wr(a_prio(3), 32'hFFFF_FFFD); rd(a_prio(3), r); chk(r == 5, "R2 prio mask", r, 5);
    wr(a_prio(0), 7); rd(a_prio(0), r); chk(r == 0, "R2 id0 word", r, 0);

    // R3 enable layout
    wr(a_en(1, 1), 32'hFFFF_FFFF); rd(a_en(1, 1), r); chk(r == 32'h1FF, "R3 upper word", r, 32'h1FF);
    wr(a_en(0, 0), 32'hFFFF_FFFF); rd(a_en(0, 0), r); chk(r == 32'hFFFF_FFFE, "R3 bit0", r, 32'hFFFF_FFFE);
    wr(a_en(0, 1), 32'hFFFF_FFFF);

    // R6 priority and tie-break
    wr(a_prio(2), 2); wr(a_prio(4), 3); wr(a_prio(6), 3); wr(a_prio(3), 0);
    lvl[1] = 1; lvl[2] = 1; lvl[3] = 1; lvl[5] = 1;
    rd(22'h003000, r); chk(r == 0, "R12 unmapped read", r, 0);
    chk(irq_out[0] == 1, "R7 ctx0 raised", 32'(irq_out[0]), 1);
    chk(irq_out[1] == 0, "R3 ctx1 not enabled", 32'(irq_out[1]), 0);
    rd(a_clm(0), r); chk(r == 4, "R6 tie to lower id", r, 4);
    rd(a_clm(0), r); chk(r == 6, "R6 second", r, 6);
    rd(a_clm(0), r); chk(r == 2, "R8 lower prio last", r, 2);
    rd(a_clm(0), r); chk(r == 0, "R5 prio0 never eligible", r, 0);
    chk(irq_out[0] == 0, "R9 held level no repend", 32'(irq_out[0]), 0);
    wr(a_prio(3), 1); rd(a_clm(0), r); chk(r == 3, "R5 prio raised", r, 3);

    // R11 bogus completions
    wr(a_clm(0), 0); wr(a_clm(0), 45); wr(a_clm(0), 7);
    rd(a_clm(0), r); chk(r == 0, "R11 bogus completion ignored", r, 0);

    // R10 completion and one-cycle gap
    wr(a_clm(0), 4);
    rd(a_clm(0), r); chk(r == 0, "R10 gap cycle", r, 0);
    rd(a_clm(0), r); chk(r == 4, "R10 repend after complete", r, 4);

    // R5 strict threshold
    wr(a_clm(0), 6);
    wr(a_thr(0), 3); chk(irq_out[0] == 0, "R5 equal to threshold", 32'(irq_out[0]), 0);
    rd(a_clm(0), r); chk(r == 0, "R5 claim blocked", r, 0);
    wr(a_thr(0), 2); chk(irq_out[0] == 1, "R5 above threshold", 32'(irq_out[0]), 1);
    rd(a_clm(0), r); chk(r == 6, "R4 claim ctx0", r, 6);

    // R12 misaligned and unmapped writes
    wr(a_prio(4) + 1, 7); rd(a_prio(4), r); chk(r == 3, "R12 misaligned write", r, 3);
    rd(a_prio(4) + 1, r); chk(r == 0, "R12 misaligned read", r, 0);
    rd(22'h200008, r); chk(r == 0, "R12 ctx hole", r, 0);

    // Random traffic
    for (int k = 0; k < 4000; k++) begin
      int op = int'($urandom % 10);
      int c = int'($urandom % N_CTX);
      if ($urandom % 3 == 0) begin
        int b = int'($urandom % N_SRC);
        lvl[b] = ~lvl[b];
      end
      case (op)
        0, 1, 2: rd(a_clm(c), r);
        3: wr(a_clm(c), ($urandom % 4 == 0) ? ($urandom % 64) : (1 + $urandom % N_SRC));
        4: wr(a_prio(1 + int'($urandom % N_SRC)), $urandom);
        5: wr(a_en(c, int'($urandom % 2)), $urandom);
        6: wr(a_thr(c), $urandom % 5);
        7: rd(a_prio(int'($urandom % (N_SRC + 1))), r);
        8: rd(22'($urandom), r);
        default: cyc(0, 0, 0, 0, r);
      endcase
    end

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule